// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block generates four independent pulse-width-modulated outputs. Software programs it through a small word-addressed register bus. The bus has an address, write data, a write strobe and a combinational read-data return. One shared control word holds a run bit and a 2-bit step-prescaler code for every channel. Each channel also has its own configuration word, which packs a period length and a high-time. Both values are counted in prescaled step ticks.

Once a channel runs, its prescaler produces a step tick every 1, 8, 64 or 512 clock cycles. Its step counter sweeps from 0 to one less than the period. The output is high while the step count is below the high-time. A new period or high-time is held in the register and reaches the counters only at a period boundary, so a running waveform never shows a partial pulse. Stopping a channel forces its pin low at once and clears its counters. Starting it again begins a fresh period at step 0.

Top module: `pwm_quad`

## Requirements
- R1: Word address 0 is the control word. Bit n (n = 0..3) is the run bit of channel n. Bits [2n+5:2n+4] hold channel n's prescaler code. A write to word 0 replaces all of these bits.
- R2: Prescaler codes 0, 1, 2 and 3 give one step tick every 1, 8, 64 and 512 clock cycles. A running channel with period P > 0 and high-time D repeats every P*div cycles and is high for min(D,P)*div cycles of each repeat.
- R3: Word address n+1 is channel n's configuration word. The period is in bits [7:0] and the high-time is in bits [23:16]. Bits [15:8] and [31:24] of a write are ignored, so only the low 8 bits of each 16-bit field matter.
- R4: Reads return the last value written. Unused bits read 0: control bits [31:12] and configuration bits [31:24] and [15:8]. Word addresses 5 to 7 read 0, and writes to them change no register.
- R5: A high-time of 0 keeps the output low. A high-time equal to or above the period keeps it high for the whole run.
- R6: A period of 0 holds the output low while the channel runs.
- R7: A configuration write while the channel runs does not change the current period. The new values take effect from the next period boundary.
- R8: Clearing a run bit drives that output low from the cycle after the write and clears its counters. Setting the run bit starts a fresh period at step 0, with the first step in the high phase whenever the high-time is nonzero. A stopped channel's output is always low.
- R9: Channels are independent. A channel's output depends only on its own run bit, prescaler code and configuration word.
- R10: After the asynchronous reset, all registers read 0 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pwm_o | output | 4 | Channel outputs, bit n for channel n |

## Verification
The bound checker watches the register side on every cycle:
- It checks that the control word changes only on a write to word 0, and then to exactly the written bits.
- It checks that padding bits and unmapped words always read zero.
- It checks that no stopped channel ever drives its pin high.

Waveform shape can only be shown by the bench's scenarios. This covers the high-count for each prescaler code, the deferral of a mid-period configuration write to the next boundary, the fresh restart after a stop, and the zero-period and saturated high-time cases. The bench measures these by counting high samples over whole periods.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int DATA_W   = 32;
  localparam int CODE_W   = 2;
  localparam int DUTY_LSB = 16;
  localparam int PRE_W    = 9;   // holds divide-by-512 count

  typedef enum logic [CODE_W-1:0] {
    PRE_DIV1   = 2'd0,
    PRE_DIV8   = 2'd1,
    PRE_DIV64  = 2'd2,
    PRE_DIV512 = 2'd3
  } pre_code_e;

  // Terminal count of the prescaler for a given code (divisor - 1).
  function automatic logic [PRE_W-1:0] pre_limit(input logic [CODE_W-1:0] code);
    case (pre_code_e'(code))
      PRE_DIV1:   pre_limit = PRE_W'(0);
      PRE_DIV8:   pre_limit = PRE_W'(7);
      PRE_DIV64:  pre_limit = PRE_W'(63);
      default:    pre_limit = PRE_W'(511);
    endcase
  endfunction
endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
  import pwm_quad_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int FIELD_W = 8,
  parameter int ADDR_W  = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic                           we_i,
  output logic [DATA_W-1:0]              rdata_o,
  output logic [NCH-1:0]                 en_o,
  output logic [NCH-1:0][CODE_W-1:0]     code_o,
  output logic [NCH-1:0][FIELD_W-1:0]    tb_o,
  output logic [NCH-1:0][FIELD_W-1:0]    duty_o
);
  localparam int CODE_LSB = NCH;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      code_o <= '0;
      tb_o   <= '0;
      duty_o <= '0;
    end else if (we_i) begin
      if (addr_i == '0) begin
        en_o <= wdata_i[NCH-1:0];
        for (int n = 0; n < NCH; n++)
          code_o[n] <= wdata_i[CODE_LSB + CODE_W*n +: CODE_W];
      end
      for (int n = 0; n < NCH; n++) begin
        if (addr_i == ADDR_W'(n + 1)) begin
          tb_o[n]   <= wdata_i[0 +: FIELD_W];
          duty_o[n] <= wdata_i[DUTY_LSB +: FIELD_W];
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) begin
      rdata_o[NCH-1:0] = en_o;
      for (int n = 0; n < NCH; n++)
        rdata_o[CODE_LSB + CODE_W*n +: CODE_W] = code_o[n];
    end
    for (int n = 0; n < NCH; n++) begin
      if (addr_i == ADDR_W'(n + 1)) begin
        rdata_o[0 +: FIELD_W]        = tb_o[n];
        rdata_o[DUTY_LSB +: FIELD_W] = duty_o[n];
      end
    end
  end
endmodule

// File: rtl/pwm_quad_prescaler.sv
module pwm_quad_prescaler
  import pwm_quad_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] limit;

  assign limit  = pre_limit(code_i);
  assign tick_o = run_i && (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q >= limit) cnt_q <= '0;  // >= covers a code lowered mid-count
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_quad_channel.sv
module pwm_quad_channel #(
  parameter int FIELD_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               tick_i,
  input  logic [FIELD_W-1:0] tb_i,
  input  logic [FIELD_W-1:0] duty_i,
  output logic               pwm_o
);
  logic [FIELD_W-1:0] step_q, tb_q, duty_q;
  logic               wrap;

  assign wrap  = (tb_q == '0) || (step_q == tb_q - 1'b1);
  assign pwm_o = run_i && (tb_q != '0) && (step_q < duty_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      tb_q   <= '0;
      duty_q <= '0;
    end else if (!run_i) begin
      // stopped: track the programmed values so a start uses them at once
      step_q <= '0;
      tb_q   <= tb_i;
      duty_q <= duty_i;
    end else if (tick_i) begin
      if (wrap) begin
        step_q <= '0;
        tb_q   <= tb_i;
        duty_q <= duty_i;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int FIELD_W = 8,
  parameter int ADDR_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NCH-1:0]    pwm_o
);
  localparam int CTRL_W = NCH * (1 + CODE_W);

  logic [NCH-1:0]              ctrl_en;
  logic [NCH-1:0][CODE_W-1:0]  ctrl_code;
  logic [NCH-1:0][FIELD_W-1:0] cfg_tb, cfg_duty;
  logic [CTRL_W-1:0]           ctrl_bits;
  logic [NCH-1:0]              step_tick;

  assign ctrl_bits = {ctrl_code, ctrl_en};

  pwm_quad_regs #(.NCH(NCH), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .we_i    (we_i),
    .rdata_o (rdata_o),
    .en_o    (ctrl_en),
    .code_o  (ctrl_code),
    .tb_o    (cfg_tb),
    .duty_o  (cfg_duty)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_quad_prescaler u_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (ctrl_en[g]),
      .code_i (ctrl_code[g]),
      .tick_o (step_tick[g])
    );

    pwm_quad_channel #(.FIELD_W(FIELD_W)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (ctrl_en[g]),
      .tick_i (step_tick[g]),
      .tb_i   (cfg_tb[g]),
      .duty_i (cfg_duty[g]),
      .pwm_o  (pwm_o[g])
    );
  end
endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk
  import pwm_quad_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int FIELD_W = 8,
  parameter int ADDR_W  = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [DATA_W-1:0]          wdata_i,
  input logic                       we_i,
  input logic [DATA_W-1:0]          rdata_o,
  input logic [NCH-1:0]             pwm_o,
  input logic [NCH-1:0]             en_i,
  input logic [NCH*(1+CODE_W)-1:0]  ctrl_i
);
  localparam int CTRL_W = NCH * (1 + CODE_W);

  logic ctrl_wr, cfg_sel, unmapped;
  assign ctrl_wr  = we_i && (addr_i == '0);
  assign cfg_sel  = (addr_i != '0) && (addr_i <= ADDR_W'(NCH));
  assign unmapped = addr_i > ADDR_W'(NCH);

  AST_STOPPED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_o & ~en_i) == '0);  // R8

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> $stable(ctrl_i));  // R1

  AST_CTRL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> ctrl_i == $past(wdata_i[CTRL_W-1:0]));  // R1

  AST_CTRL_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == '0) |-> rdata_o[DATA_W-1:CTRL_W] == '0);  // R4

  AST_CFG_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_sel |-> (rdata_o[DATA_W-1:DUTY_LSB+FIELD_W] == '0) &&
                (rdata_o[DUTY_LSB-1:FIELD_W] == '0));  // R4

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped |-> rdata_o == '0);  // R4
endmodule

bind pwm_quad pwm_quad_chk #(.NCH(NCH), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .we_i    (we_i),
  .rdata_o (rdata_o),
  .pwm_o   (pwm_o),
  .en_i    (ctrl_en),
  .ctrl_i  (ctrl_bits)
);

// File: tb/tb_pwm_quad.sv
module tb_pwm_quad;
  localparam int AW = 3;
  localparam int NV = 9;
  // {channel[1:0], code[1:0], period[15:0], high_time[15:0]}
  localparam logic [35:0] VEC [NV] = '{
    {2'd0, 2'd0, 16'd4,      16'd1},
    {2'd1, 2'd0, 16'd5,      16'd5},
    {2'd2, 2'd1, 16'd3,      16'd2},
    {2'd3, 2'd2, 16'd2,      16'd1},
    {2'd0, 2'd3, 16'd2,      16'd1},
    {2'd1, 2'd0, 16'd6,      16'd0},
    {2'd2, 2'd0, 16'd0,      16'd3},
    {2'd3, 2'd1, 16'd4,      16'd9},
    {2'd0, 2'd0, 16'h0104,   16'h0302}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic          we = 1'b0;
  logic [31:0]   rdata;
  logic [3:0]    pwm;
  int            n_chk = 0, n_err = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  pwm_quad dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .rdata_o(rdata), .pwm_o(pwm)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // starts just after a falling edge, returns at the next falling edge
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    #1 we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic count(input int ch, input int w, output int hi, output int other);
    hi = 0; other = 0;
    for (int i = 0; i < w; i++) begin
      if (pwm[ch]) hi++;
      if ((pwm & ~(4'b1 << ch)) != 4'b0) other++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int hi, oth, hi1, hi2;

    repeat (3) @(negedge clk);
    check("R10 outputs in reset", 32'(pwm), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 5; a++) begin
      rd(AW'(a), r);
      check("R10 register reset", r, 32'h0);
    end
    @(negedge clk);

    // table walk
    for (int v = 0; v < NV; v++) begin
      int ch, code, div, tb, du, win, exp_hi;
      logic [15:0] raw_tb;
      logic [31:0] ctrl;
      string tag;
      ch     = int'(VEC[v][35:34]);
      code   = int'(VEC[v][33:32]);
      raw_tb = VEC[v][31:16];
      tb     = int'(VEC[v][23:16]);
      du     = int'(VEC[v][7:0]);
      div    = 1 << (3 * code);
      win    = (tb == 0) ? 16 : 2 * tb * div;
      exp_hi = (tb == 0) ? 0 : 2 * ((du < tb) ? du : tb) * div;
      if (raw_tb[15:8] != 8'h0)       tag = "R3";
      else if (tb == 0)               tag = "R6";
      else if (du == 0 || du >= tb)   tag = "R5";
      else                            tag = "R2";
      ctrl = (32'h1 << ch) | (32'(code) << (4 + 2 * ch));
      wr(AW'(ch + 1), {VEC[v][15:0], VEC[v][31:16]});
      wr(AW'(0), ctrl);
      count(ch, win, hi, oth);
      check(tag, 32'(hi), 32'(exp_hi));
      check("R9 other pins idle", 32'(oth), 32'h0);
      rd(AW'(0), r);
      check("R1 control readback", r, ctrl);
      wr(AW'(0), 32'h0);
    end

    // R7: change during a period is deferred to the next boundary
    wr(AW'(1), 32'h0002_0008);
    wr(AW'(0), 32'h1);
    hi1 = 0;
    for (int i = 0; i < 3; i++) begin
      if (pwm[0]) hi1++;
      @(negedge clk);
    end
    if (pwm[0]) hi1++;
    wr(AW'(1), 32'h0006_0008);
    for (int i = 0; i < 4; i++) begin
      if (pwm[0]) hi1++;
      @(negedge clk);
    end
    count(0, 8, hi2, oth);
    check("R7 current period keeps old high-time", 32'(hi1), 32'd2);
    check("R7 next period uses new high-time", 32'(hi2), 32'd6);
    wr(AW'(0), 32'h0);

    // R8: stop is immediate, restart is fresh
    wr(AW'(1), 32'h0008_0008);
    wr(AW'(0), 32'h1);
    check("R8 started high", 32'(pwm[0]), 32'h1);
    @(negedge clk);
    wr(AW'(0), 32'h0);
    check("R8 low after stop", 32'(pwm[0]), 32'h0);
    wr(AW'(1), 32'h0001_0002);
    wr(AW'(0), 32'h11);
    count(0, 8, hi1, oth);
    count(0, 8, hi2, oth);
    check("R8 fresh start high phase", 32'(hi1), 32'd8);
    check("R8 fresh start low phase", 32'(hi2), 32'd0);
    wr(AW'(0), 32'h0);

    // R9: two channels together
    wr(AW'(2), 32'h0001_0004);
    wr(AW'(3), 32'h0003_0004);
    wr(AW'(0), 32'h6);
    hi1 = 0; hi2 = 0; oth = 0;
    for (int i = 0; i < 8; i++) begin
      if (pwm[1]) hi1++;
      if (pwm[2]) hi2++;
      if (pwm[0] || pwm[3]) oth++;
      @(negedge clk);
    end
    check("R9 channel 1", 32'(hi1), 32'd2);
    check("R9 channel 2", 32'(hi2), 32'd6);
    check("R9 idle channels", 32'(oth), 32'd0);
    wr(AW'(0), 32'h0);

    // R4: masking and unmapped words
    wr(AW'(0), 32'hFFFF_FFFF);
    rd(AW'(0), r);
    check("R4 control padding", r, 32'h0000_0FFF);
    wr(AW'(0), 32'h0);
    wr(AW'(2), 32'hFFFF_FFFF);
    rd(AW'(2), r);
    check("R4 config padding", r, 32'h00FF_00FF);
    wr(AW'(5), 32'h1234_5678);
    wr(AW'(7), 32'hFFFF_FFFF);
    rd(AW'(5), r);
    check("R4 unmapped word 5", r, 32'h0);
    rd(AW'(7), r);
    check("R4 unmapped word 7", r, 32'h0);
    rd(AW'(2), r);
    check("R4 config unchanged", r, 32'h00FF_00FF);
    rd(AW'(0), r);
    check("R4 control unchanged", r, 32'h0);
    check("R4 no output from unmapped write", 32'(pwm), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule